// File: doc/BRIEF.md
# Digital Read-Pulse Data Separator

This block recovers bit timing from the raw read pulses of a floppy drive. The asynchronous pulse line is first brought into the core clock domain. An edge detector turns each pulse into a one-cycle event. A half-cell counter drives a window signal whose two states frame the two halves of every bit cell. The high state frames the data half and the low state frames the clock half. A pulse that lands in a half marks that half's bit as one.

Each pulse pulls the counter at once toward the centre of the current half, by half of the measured phase error. A fractional integrator takes in the same error and slowly moves the half-cell length to follow drift in the spindle rate. The integrator cannot move the length more than a set percentage away from nominal. After a run of pulses that all land close to the centre, the block declares lock. While locked, a serial-to-parallel stage gathers eight cells and presents them as a data byte and a clock byte, with a one-cycle valid strobe.

The surrounding controller uses the strobe and window as its synchronized read clock. It takes the byte pair for sync-mark search and framing.

Top module: `rd_data_separator`

## Requirements
- R1: Each rising edge of `rd_in` held for at least two clocks gives exactly one single-cycle `rd_strobe`. The strobe is high in the cycle after the third rising clock edge, counting from the first edge that samples `rd_in` high.
- R2: While `rst_n` is low at a clock edge, the outputs become: `rd_win`=1, `locked`=0, `rd_strobe`=0, `byte_vld`=0, and both bytes zero. The first window high phase after reset release lasts exactly HALF_NOM clocks.
- R3: With no pulses arriving, `rd_win` alternates, and each high phase and each low phase lasts exactly the current half-cell length in clocks.
- R4: A pulse seen at counter position p, with mid = floor(length/2), loads the counter with p+1-floor((p-mid)/2). With a nominal length of 32, a pulse at p=10 ends its half 3 clocks early, and a pulse at p=22 ends it 3 clocks late.
- R5: A pulse is a hit when |p-mid| <= floor(length/4). `locked` rises right after the LOCK_N-th consecutive hit (8 by default), and not after LOCK_N-1 hits.
- R6: A pulse that is not a hit clears `locked` in the cycle after it is processed and restarts the hit count, so LOCK_N further hits are needed to relock.
- R7: While locked, every 8 cells give one single-cycle `byte_vld`. The pulses of each cell's data half (window=1, which comes first) become one bit of `data_byte`. The pulses of the clock half (window=0) become one bit of `clk_byte`. Both bytes cover the same 8 cells, with the earliest cell in bit 7.
- R8: `byte_vld` is never high while `locked` is low.
- R9: Given a steady pulse stream whose half-cell length lies inside the allowed range, the free-running half length settles to within one clock of the stream's half length.
- R10: The half-cell length never leaves [HALF_NOM - floor(HALF_NOM*TOL_PCT/100), HALF_NOM + floor(HALF_NOM*TOL_PCT/100)]. A stream that is faster or slower than this range leaves the length pinned at the nearer bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_in | input | 1 | Raw asynchronous read pulses from the drive |
| rd_strobe | output | 1 | One-cycle synchronized pulse per read pulse |
| rd_win | output | 1 | Window: 1 = data half, 0 = clock half |
| locked | output | 1 | Separator has acquired lock |
| data_byte | output | BYTE_W | Data bits of the last eight cells |
| clk_byte | output | BYTE_W | Clock bits of the last eight cells |
| byte_vld | output | 1 | One-cycle strobe marking a new byte pair |

## Verification
The bench measures the first window half after reset with a pulse placed six clocks early and then six clocks late. A design that gets the sign or the halving of the correction wrong shifts that edge the wrong way or by the wrong amount. Lock is probed after seven and after eight centred pulses, and again after one pulse displaced past the quarter-cell limit. An off-by-one counter locks a pulse too soon, and a missing clear keeps `locked` high. Streams outside the tolerance band are used to push the integrator against both bounds, so a missing or inverted clamp shows up as a wrong free-running window length. Byte patterns with unequal data and clock bits expose swapped halves, reversed bit order and bytes assembled from misaligned cells.

// File: rtl/rdsep_pkg.sv
// Package: shared types and constant helpers for the read-pulse data separator.
// Assumes: callers pass non-negative nominal lengths and tolerance percentages.
package rdsep_pkg;

    // Which half of a bit cell the window currently frames.
    typedef enum logic {
        HALF_CLK  = 1'b0,
        HALF_DATA = 1'b1
    } half_e;

    // Shortest half-cell length the integrator may reach.
    function automatic int half_floor(input int nom, input int tol_pct);
        return nom - (nom * tol_pct) / 100;
    endfunction

    // Longest half-cell length the integrator may reach.
    function automatic int half_ceil(input int nom, input int tol_pct);
        return nom + (nom * tol_pct) / 100;
    endfunction

endpackage

// File: rtl/rdsep_sync.sv
// Module: brings the asynchronous read-pulse line into the clock domain through
// a flop chain and emits a one-cycle event on each rising edge.
// Assumes: pulses are high for at least two clocks; STAGES >= 2.
module rdsep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_in,
    output logic evt
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // First stage samples the raw line.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= rd_in;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Each further stage resamples the stage before it.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[s] <= 1'b0;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    endgenerate

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    // Rising edge of the synchronized level.
    assign evt = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/rdsep_integ.sv
// Module: speed-tracking integrator. Holds the half-cell length as a fixed-point
// value with FRAC_W fraction bits, adds each pulse's phase error in fraction
// units, clamps to the tolerance band and rounds to whole clocks.
// Assumes: err is the signed offset of a pulse from mid-window, valid when upd=1.
module rdsep_integ
    import rdsep_pkg::*;
#(
    parameter int HALF_NOM = 200,
    parameter int CNT_W    = 10,
    parameter int FRAC_W   = 5,
    parameter int TOL_PCT  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd,
    input  logic signed [CNT_W:0]   err,
    output logic [CNT_W-1:0]        half_period
);

    localparam int ACC_W   = CNT_W + FRAC_W + 2;
    localparam int MIN_I   = half_floor(HALF_NOM, TOL_PCT) * (2 ** FRAC_W);
    localparam int MAX_I   = half_ceil(HALF_NOM, TOL_PCT) * (2 ** FRAC_W);
    localparam int NOM_I   = HALF_NOM * (2 ** FRAC_W);
    localparam int ROUND_I = (2 ** FRAC_W) / 2;

    localparam logic signed [ACC_W-1:0] MIN_Q   = ACC_W'(MIN_I);
    localparam logic signed [ACC_W-1:0] MAX_Q   = ACC_W'(MAX_I);
    localparam logic signed [ACC_W-1:0] NOM_Q   = ACC_W'(NOM_I);
    localparam logic signed [ACC_W-1:0] ROUND_Q = ACC_W'(ROUND_I);

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] sum;
    logic signed [ACC_W-1:0] bounded;

    // Candidate length after adding this pulse's error.
    assign sum = acc_q + ACC_W'(err);

    // Hold the candidate inside the tolerance band.
    always_comb begin
        if (sum < MIN_Q)      bounded = MIN_Q;
        else if (sum > MAX_Q) bounded = MAX_Q;
        else                  bounded = sum;
    end

    // Integrator register: nominal at reset, updated once per pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)   acc_q <= NOM_Q;
        else if (upd) acc_q <= bounded;
    end

    // Whole-clock length, rounded to nearest.
    assign half_period = CNT_W'((acc_q + ROUND_Q) >>> FRAC_W);

endmodule

// File: rtl/rdsep_phase.sv
// Module: window control and phase error adjustment. A counter runs through each
// half cell; at its end the window flips. A pulse measures its offset from
// mid-window and reloads the counter halfway toward the centre. Consecutive
// near-centre pulses build up lock.
// Assumes: evt is a one-cycle synchronized event; half_period >= 4.
module rdsep_phase
    import rdsep_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int LOCK_N = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  evt,
    input  logic [CNT_W-1:0]      half_period,
    output logic signed [CNT_W:0] err,
    output logic                  half_end,
    output half_e                 win,
    output logic                  strobe,
    output logic                  locked
);

    localparam int ERR_W = CNT_W + 1;
    localparam int LCK_W = $clog2(LOCK_N + 1);
    localparam logic [LCK_W-1:0] LOCK_FULL = LCK_W'(LOCK_N);

    logic [CNT_W-1:0]        ph_q;
    half_e                   win_q;
    logic [LCK_W-1:0]        run_q;
    logic                    strobe_q;
    logic [CNT_W-1:0]        mid;
    logic [CNT_W-1:0]        quarter;
    logic signed [ERR_W-1:0] half_err;
    logic [ERR_W:0]          corr;
    logic [ERR_W-1:0]        mag;
    logic                    wrap;
    logic                    hit;

    assign mid     = half_period >> 1;
    assign quarter = half_period >> 2;

    // Signed pulse offset from the centre of the current half.
    assign err = $signed({1'b0, ph_q}) - $signed({1'b0, mid});

    // Half of the error, rounded toward minus infinity.
    assign half_err = err >>> 1;

    // Counter value after pulling halfway toward the centre.
    assign corr = {2'b00, ph_q} + (ERR_W + 1)'(1) - {half_err[ERR_W-1], half_err};

    // Error magnitude and hit test against a quarter of the half cell.
    assign mag  = err[ERR_W-1] ? ERR_W'(-err) : ERR_W'(err);
    assign hit  = mag <= {1'b0, quarter};

    // End of the current half when no pulse overrides the counter.
    assign wrap     = ph_q >= (half_period - CNT_W'(1));
    assign half_end = !evt && wrap;

    // Phase counter and window: correction on a pulse, else count and flip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= '0;
            win_q <= HALF_DATA;
        end else if (evt) begin
            ph_q  <= CNT_W'(corr);
        end else if (wrap) begin
            ph_q  <= '0;
            win_q <= (win_q == HALF_DATA) ? HALF_CLK : HALF_DATA;
        end else begin
            ph_q  <= ph_q + CNT_W'(1);
        end
    end

    // Count consecutive hits, saturating; any miss restarts the run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (evt) begin
            if (!hit)                   run_q <= '0;
            else if (run_q != LOCK_FULL) run_q <= run_q + LCK_W'(1);
        end
    end

    // Registered read-data strobe, one per pulse event.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= evt;
    end

    assign win    = win_q;
    assign strobe = strobe_q;
    assign locked = (run_q == LOCK_FULL);

endmodule

// File: rtl/rdsep_shift.sv
// Module: serial-to-parallel stage. Notes whether a pulse fell in the current
// half, shifts that bit into the data or clock register when the half ends,
// and presents a byte pair after every BYTE_W cells while locked.
// Assumes: evt and half_end never coincide; a cell is a data half then a clock half.
module rdsep_shift
    import rdsep_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic              half_end,
    input  half_e             win,
    input  logic              locked,
    output logic [BYTE_W-1:0] data_byte,
    output logic [BYTE_W-1:0] clk_byte,
    output logic              byte_vld
);

    localparam int BC_W = $clog2(BYTE_W);
    localparam logic [BC_W-1:0] LAST_BIT = BC_W'(BYTE_W - 1);

    logic              seen_q;
    logic [BYTE_W-1:0] dsh_q;
    logic [BYTE_W-1:0] csh_q;
    logic [BC_W-1:0]   cnt_q;
    logic [BYTE_W-1:0] dout_q;
    logic [BYTE_W-1:0] cout_q;
    logic              vld_q;

    // Pulse-seen flag for the half in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)        seen_q <= 1'b0;
        else if (evt)      seen_q <= 1'b1;
        else if (half_end) seen_q <= 1'b0;
    end

    // Shift the finished half's bit into the matching register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsh_q <= '0;
            csh_q <= '0;
        end else if (half_end) begin
            if (win == HALF_DATA) dsh_q <= {dsh_q[BYTE_W-2:0], seen_q};
            else                  csh_q <= {csh_q[BYTE_W-2:0], seen_q};
        end
    end

    // Cell counter and byte hand-off, held idle while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            dout_q <= '0;
            cout_q <= '0;
            vld_q  <= 1'b0;
        end else if (!locked) begin
            cnt_q  <= '0;
            vld_q  <= 1'b0;
        end else if (half_end && win == HALF_CLK) begin
            cnt_q <= cnt_q + BC_W'(1);
            vld_q <= (cnt_q == LAST_BIT);
            if (cnt_q == LAST_BIT) begin
                dout_q <= dsh_q;
                cout_q <= {csh_q[BYTE_W-2:0], seen_q};
            end
        end else begin
            vld_q <= 1'b0;
        end
    end

    assign data_byte = dout_q;
    assign clk_byte  = cout_q;
    assign byte_vld  = vld_q;

endmodule

// File: rtl/rd_data_separator.sv
// Module: top of the digital data separator. Wires the synchronizer, the window
// and phase control, the speed integrator and the byte assembler together.
// Assumes: a free-running core clock well above the pulse rate; HALF_NOM gives
// the nominal half-cell length in clocks.
module rd_data_separator
    import rdsep_pkg::*;
#(
    parameter int HALF_NOM    = 200,
    parameter int CNT_W       = 10,
    parameter int FRAC_W      = 5,
    parameter int TOL_PCT     = 12,
    parameter int LOCK_N      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_in,
    output logic              rd_strobe,
    output logic              rd_win,
    output logic              locked,
    output logic [BYTE_W-1:0] data_byte,
    output logic [BYTE_W-1:0] clk_byte,
    output logic              byte_vld
);

    logic                  evt;
    logic                  half_end;
    logic signed [CNT_W:0] err;
    logic [CNT_W-1:0]      half_period;
    half_e                 win;

    rdsep_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_in (rd_in),
        .evt   (evt)
    );

    rdsep_phase #(
        .CNT_W  (CNT_W),
        .LOCK_N (LOCK_N)
    ) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt         (evt),
        .half_period (half_period),
        .err         (err),
        .half_end    (half_end),
        .win         (win),
        .strobe      (rd_strobe),
        .locked      (locked)
    );

    rdsep_integ #(
        .HALF_NOM (HALF_NOM),
        .CNT_W    (CNT_W),
        .FRAC_W   (FRAC_W),
        .TOL_PCT  (TOL_PCT)
    ) u_integ (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd         (evt),
        .err         (err),
        .half_period (half_period)
    );

    rdsep_shift #(
        .BYTE_W (BYTE_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .half_end  (half_end),
        .win       (win),
        .locked    (locked),
        .data_byte (data_byte),
        .clk_byte  (clk_byte),
        .byte_vld  (byte_vld)
    );

    assign rd_win = (win == HALF_DATA);

endmodule

// File: rtl/rdsep_checker.sv
// Module: property checker for the data separator, attached by bind.
// Assumes: the half_period net of the top is visible at the bind site.
module rdsep_checker
    import rdsep_pkg::*;
#(
    parameter int HALF_NOM = 200,
    parameter int CNT_W    = 10,
    parameter int TOL_PCT  = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_strobe,
    input logic             locked,
    input logic             byte_vld,
    input logic [CNT_W-1:0] half_period
);

    localparam logic [CNT_W-1:0] LO = CNT_W'(half_floor(HALF_NOM, TOL_PCT));
    localparam logic [CNT_W-1:0] HI = CNT_W'(half_ceil(HALF_NOM, TOL_PCT));

    // R1: a read strobe never lasts two cycles.
    p_strobe_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> !rd_strobe);

    // R5: lock is only gained on the cycle a pulse is reported.
    p_lock_on_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> rd_strobe);

    // R6: lock is only lost on the cycle a pulse is reported.
    p_unlock_on_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> rd_strobe);

    // R7: a byte strobe is a single cycle.
    p_byte_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld);

    // R8: bytes only appear while locked.
    p_byte_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> locked);

    // R10: the integrator output stays inside the tolerance band.
    p_period_band_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (half_period >= LO) && (half_period <= HI));

endmodule

bind rd_data_separator rdsep_checker #(
    .HALF_NOM (HALF_NOM),
    .CNT_W    (CNT_W),
    .TOL_PCT  (TOL_PCT)
) u_rdsep_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_strobe   (rd_strobe),
    .locked      (locked),
    .byte_vld    (byte_vld),
    .half_period (half_period)
);

// File: tb/rd_data_separator_bench.sv
`timescale 1ns/1ps
module rd_data_separator_bench;

    localparam int H     = 32;
    localparam int HMIN  = H - (H * 12) / 100;
    localparam int HMAX  = H + (H * 12) / 100;
    localparam int NVEC  = 6;
    // Each entry: data pattern in [15:8], clock pattern in [7:0].
    localparam logic [15:0] VEC [NVEC] = '{
        16'hFF00, 16'h00FF, 16'hA55A, 16'hC33C, 16'h8112, 16'hF00F
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_in = 1'b0;
    logic       rd_strobe, rd_win, locked, byte_vld;
    logic [7:0] data_byte, clk_byte;

    int checks = 0;
    int failures = 0;
    int byte_cnt = 0;
    int strobe_cnt = 0;
    logic [7:0] last_d = 8'h00;
    logic [7:0] last_c = 8'h00;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rd_data_separator #(
        .HALF_NOM (H),
        .CNT_W    (8)
    ) u_rd_data_separator (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_in     (rd_in),
        .rd_strobe (rd_strobe),
        .rd_win    (rd_win),
        .locked    (locked),
        .data_byte (data_byte),
        .clk_byte  (clk_byte),
        .byte_vld  (byte_vld)
    );

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && byte_vld) begin
            byte_cnt <= byte_cnt + 1;
            last_d   <= data_byte;
            last_c   <= clk_byte;
        end
        if (rst_n && rd_strobe) strobe_cnt <= strobe_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reset, ending at the falling edge just before the first live rising edge.
    task automatic do_reset();
        rst_n = 1'b0;
        rd_in = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One bit cell: optional data pulse at offset off, optional clock pulse one half later.
    task automatic send_cell(input bit d, input bit c, input int hp, input int off);
        for (int k = 0; k < 2 * hp; k++) begin
            rd_in = (d && k >= off && k < off + 4) || (c && k >= hp && k < hp + 4);
            @(negedge clk);
        end
        rd_in = 1'b0;
    endtask

    task automatic measure_high(output int n);
        while (rd_win)  @(negedge clk);
        while (!rd_win) @(negedge clk);
        n = 0;
        while (rd_win) begin n++; @(negedge clk); end
    endtask

    task automatic measure_low(output int n);
        while (!rd_win) @(negedge clk);
        while (rd_win)  @(negedge clk);
        n = 0;
        while (!rd_win) begin n++; @(negedge clk); end
    endtask

    // First data-half length after reset, with an optional pulse raised before edge j.
    task automatic first_half(input int j, output int n);
        int i;
        do_reset();
        n = 1;
        i = 1;
        forever begin
            if (i == j && j > 0) rd_in = 1'b1;
            if (i == j + 4)      rd_in = 1'b0;
            @(negedge clk);
            if (!rd_win) break;
            n++;
            i++;
        end
        rd_in = 1'b0;
    endtask

    // Start a centred nominal stream and lock with a data-only preamble.
    task automatic start_stream(input int cells);
        do_reset();
        repeat (14) @(negedge clk);
        for (int k = 0; k < cells; k++) send_cell(1'b1, 1'b0, H, 0);
    endtask

    function automatic logic [7:0] rol8(input logic [7:0] v, input int r);
        return (v << r) | (v >> (8 - r));
    endfunction

    function automatic bit rot_match(input logic [7:0] d, input logic [7:0] c,
                                     input logic [7:0] pd, input logic [7:0] pc);
        for (int r = 0; r < 8; r++)
            if (rol8(pd, r) == d && rol8(pc, r) == c) return 1'b1;
        return 1'b0;
    endfunction

    initial begin
        int n, na, nb, b0, s0, pops;
        logic [7:0] pd, pc;

        // R2: outputs held at their reset values.
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(rd_win == 1'b1, "R2 win", int'(rd_win), 1);
        check(locked == 1'b0 && rd_strobe == 1'b0 && byte_vld == 1'b0, "R2 flags",
              int'({locked, rd_strobe, byte_vld}), 0);
        check(data_byte == 8'h00 && clk_byte == 8'h00, "R2 bytes",
              int'({data_byte, clk_byte}), 0);

        // R2 / R3 / R4: first data half, free-running and with early/late pulses.
        first_half(0, na);
        check(na == H, "R2 first half", na, H);
        measure_low(n);
        check(n == H, "R3 clock half", n, H);
        measure_high(n);
        check(n == H, "R3 data half", n, H);
        first_half(9, nb);
        check(nb == na - 3, "R4 early pulse", nb, na - 3);
        first_half(21, nb);
        check(nb == na + 3, "R4 late pulse", nb, na + 3);

        // R1: strobe latency and width.
        do_reset();
        repeat (14) @(negedge clk);
        rd_in = 1'b1;
        @(negedge clk); check(rd_strobe == 1'b0, "R1 edge+0", int'(rd_strobe), 0);
        @(negedge clk); check(rd_strobe == 1'b0, "R1 edge+1", int'(rd_strobe), 0);
        @(negedge clk); check(rd_strobe == 1'b1, "R1 edge+2", int'(rd_strobe), 1);
        @(negedge clk); check(rd_strobe == 1'b0, "R1 edge+3", int'(rd_strobe), 0);
        rd_in = 1'b0;

        // R5 / R6 / R8: lock threshold, loss on a miss, relock.
        b0 = byte_cnt;
        start_stream(7);
        check(locked == 1'b0, "R5 seven hits", int'(locked), 0);
        send_cell(1'b1, 1'b0, H, 0);
        check(locked == 1'b1, "R5 eighth hit", int'(locked), 1);
        check(byte_cnt == b0, "R8 no byte unlocked", byte_cnt - b0, 0);
        send_cell(1'b1, 1'b0, H, 12);
        check(locked == 1'b0, "R6 miss drops lock", int'(locked), 0);
        for (int k = 0; k < 7; k++) send_cell(1'b1, 1'b0, H, 0);
        check(locked == 1'b0, "R6 seven after miss", int'(locked), 0);
        send_cell(1'b1, 1'b0, H, 0);
        check(locked == 1'b1, "R6 relock", int'(locked), 1);

        // R7 / R1: vector table of data and clock patterns.
        start_stream(12);
        for (int v = 0; v < NVEC; v++) begin
            pd = VEC[v][15:8];
            pc = VEC[v][7:0];
            b0 = byte_cnt;
            s0 = strobe_cnt;
            for (int k = 0; k < 24; k++)
                send_cell(pd[7 - (k % 8)], pc[7 - (k % 8)], H, 0);
            pops = 3 * ($countones(pd) + $countones(pc));
            check(byte_cnt - b0 == 3, "R7 byte rate", byte_cnt - b0, 3);
            check(rot_match(last_d, last_c, pd, pc), "R7 byte content",
                  int'({last_d, last_c}), int'(VEC[v]));
            check(strobe_cnt - s0 == pops, "R1 strobe count", strobe_cnt - s0, pops);
        end

        // R9: tracking a slightly fast stream.
        start_stream(12);
        for (int k = 0; k < 120; k++) send_cell(1'b1, 1'b0, H - 1, 0);
        repeat (4 * H) @(negedge clk);
        measure_high(n);
        check(n >= H - 2 && n <= H, "R9 tracked length", n, H - 1);

        // R10: a stream faster than the band pins the lower bound.
        start_stream(12);
        for (int k = 0; k < 40; k++) send_cell(1'b1, 1'b0, H - 2, 0);
        for (int k = 0; k < 40; k++) send_cell(1'b1, 1'b0, H - 4, 0);
        for (int k = 0; k < 80; k++) send_cell(1'b1, 1'b0, H - 5, 0);
        repeat (4 * H) @(negedge clk);
        measure_high(n);
        check(n == HMIN, "R10 lower bound", n, HMIN);

        // R10: a stream slower than the band pins the upper bound.
        start_stream(12);
        for (int k = 0; k < 40; k++) send_cell(1'b1, 1'b0, H + 2, 0);
        for (int k = 0; k < 40; k++) send_cell(1'b1, 1'b0, H + 4, 0);
        for (int k = 0; k < 80; k++) send_cell(1'b1, 1'b0, H + 5, 0);
        repeat (4 * H) @(negedge clk);
        measure_high(n);
        check(n == HMAX, "R10 upper bound", n, HMAX);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule